// File: doc/BRIEF.md
# Configurable Four-Sided Routing Switch Box

This block sits at the crossing of a horizontal and a vertical routing channel. Each of its four sides (north, east, south, west) carries `W` incoming and `W` outgoing single-bit tracks. Every outgoing track has its own three-way multiplexer. It chooses the track arriving straight across the box, the track that reaches it by a left turn, or the track that reaches it by a right turn. An enable bit can also force the outgoing track low. Any single incoming track can therefore reach at most three outgoing tracks, one on each of the other sides.

A compile-time parameter chooses the wiring pattern. In the disjoint pattern every connection keeps its track number, so the tracks split into `W` isolated routing domains. In the Wilton pattern, straight connections keep their number and turns renumber it: a left turn takes track i to (i+1) mod W, and a right turn takes track i to W-1-i. A net can then change domain at a turn. Both patterns use the same number of switches.

The per-track choices come from a configuration word that is shifted in one bit per clock into a staging register. The word is copied into the working register only when a load strobe arrives. Routing changes all at once, and never part-way through a reload.

Top module: `sbox_switch_box`

## Requirements
- R1: A synchronous active-high `rst` clears both the staging and the working configuration. After reset every output track is 0 whatever the inputs, and a load with no shifting keeps them 0.
- R2: While `cfg_shift` is high, each rising clock edge moves the staging word one place toward bit 0 and puts `cfg_din` into the top bit, so the bit shifted first ends in bit 0. Sides are numbered north=0, east=1, south=2, west=3. Output track t of side s uses the field at bits [3k+2:3k], where k = s*W+t. Bit 3k+2 is the enable and bits [3k+1:3k] are the select.
- R3: Shifting does not change the outputs. A high `cfg_load` at a rising edge copies the staging word into the working word, and the new routing appears on the outputs after that edge.
- R4: An output track whose enable bit is 0 drives 0.
- R5: Select 0 (straight) drives output track t of side d from input track t of side (d+2) mod 4.
- R6: Select 1 (left turn) drives output track t of side d from input side (d+3) mod 4. The input track is t in the disjoint pattern and (t+W-1) mod W in the Wilton pattern.
- R7: Select 2 (right turn) drives output track t of side d from input side (d+1) mod 4. The input track is t in the disjoint pattern and W-1-t in the Wilton pattern.
- R8: Select 3 with the enable set drives the output track to 0.
- R9: With every output enabled and all outputs using the same select, one active input track appears on exactly one output track. An input never reaches more than three outputs.
- R10: West input track 0 can be routed to north output track 1 in the Wilton pattern (left turn), and cannot be routed there by any select in the disjoint pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift enable for the staging register |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy staging word into working configuration |
| in_n | input | W | Incoming tracks, north side |
| in_e | input | W | Incoming tracks, east side |
| in_s | input | W | Incoming tracks, south side |
| in_w | input | W | Incoming tracks, west side |
| out_n | output | W | Outgoing tracks, north side |
| out_e | output | W | Outgoing tracks, east side |
| out_s | output | W | Outgoing tracks, south side |
| out_w | output | W | Outgoing tracks, west side |

## Verification
The checker watches four properties on every cycle:
- the outputs are dark on the cycle after reset;
- the outputs stay steady while inputs are steady and no load has occurred;
- the number of active outputs never exceeds three times the number of active inputs;
- any active output has an active input among its three topology-defined candidates.

Other behaviour can only be shown by the bench's scenarios, running a disjoint and a Wilton instance side by side:
- the exact serial bit order and field placement;
- which candidate each select code actually picks;
- the off code and disabled sides;
- the west-0 to north-1 pair that only the Wilton pattern can route.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

   localparam int NSIDES  = 4;
   localparam int FLD_W   = 3;

   typedef enum logic {
      TOPO_DISJOINT = 1'b0,
      TOPO_WILTON   = 1'b1
   } topo_e;

   typedef enum logic [1:0] {
      SEL_STRAIGHT = 2'd0,
      SEL_LEFT     = 2'd1,
      SEL_RIGHT    = 2'd2,
      SEL_OFF      = 2'd3
   } sel_e;

   typedef struct packed {
      logic en;
      sel_e sel;
   } xcfg_t;

   function automatic int straight_side(input int d);
      return (d + 2) % NSIDES;
   endfunction

   function automatic int left_side(input int d);
      return (d + 3) % NSIDES;
   endfunction

   function automatic int right_side(input int d);
      return (d + 1) % NSIDES;
   endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
   parameter int NBITS = 84
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             din,
   input  logic             load,
   output logic [NBITS-1:0] active_o
);

   logic [NBITS-1:0] stage_q;
   logic [NBITS-1:0] active_q;

   if (NBITS < 2) begin : g_bad_len
      $error("sbox_cfg_chain: NBITS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
      end else if (shift_en) begin
         stage_q <= {din, stage_q[NBITS-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= '0;
      end else if (load) begin
         active_q <= stage_q;
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux
   import sbox_pkg::*;
(
   input  logic  straight_i,
   input  logic  left_i,
   input  logic  right_i,
   input  xcfg_t cfg_i,
   output logic  out_o
);

   logic picked;

   always_comb begin
      unique case (cfg_i.sel)
         SEL_STRAIGHT: picked = straight_i;
         SEL_LEFT:     picked = left_i;
         SEL_RIGHT:    picked = right_i;
         default:      picked = 1'b0;
      endcase
   end

   assign out_o = cfg_i.en & picked;

endmodule

// File: rtl/sbox_side.sv
module sbox_side
   import sbox_pkg::*;
#(
   parameter int    W    = 7,
   parameter topo_e TOPO = TOPO_WILTON
) (
   input  logic          [W-1:0] straight_bus,
   input  logic          [W-1:0] left_bus,
   input  logic          [W-1:0] right_bus,
   input  xcfg_t [W-1:0]         cfg_i,
   output logic          [W-1:0] out_bus
);

   logic [W-1:0] left_pick;
   logic [W-1:0] right_pick;

   for (genvar t = 0; t < W; t++) begin : g_trk
      if (TOPO == TOPO_WILTON) begin : g_wil
         localparam int LT = (t + W - 1) % W;
         localparam int RT = W - 1 - t;
         assign left_pick[t]  = left_bus[LT];
         assign right_pick[t] = right_bus[RT];
      end else begin : g_dis
         assign left_pick[t]  = left_bus[t];
         assign right_pick[t] = right_bus[t];
      end

      sbox_track_mux u_mux (
         .straight_i (straight_bus[t]),
         .left_i     (left_pick[t]),
         .right_i    (right_pick[t]),
         .cfg_i      (cfg_i[t]),
         .out_o      (out_bus[t])
      );
   end

endmodule

// File: rtl/sbox_switch_box.sv
module sbox_switch_box
   import sbox_pkg::*;
#(
   parameter int    W    = 7,
   parameter topo_e TOPO = TOPO_WILTON
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cfg_shift,
   input  logic         cfg_din,
   input  logic         cfg_load,
   input  logic [W-1:0] in_n,
   input  logic [W-1:0] in_e,
   input  logic [W-1:0] in_s,
   input  logic [W-1:0] in_w,
   output logic [W-1:0] out_n,
   output logic [W-1:0] out_e,
   output logic [W-1:0] out_s,
   output logic [W-1:0] out_w
);

   localparam int NOUT   = NSIDES * W;
   localparam int CFG_W  = NOUT * FLD_W;

   if (W < 2 || W > 64) begin : g_bad_w
      $error("sbox_switch_box: W must be within 2..64");
   end

   logic [NSIDES-1:0][W-1:0] ib;
   logic [NSIDES-1:0][W-1:0] ob;
   logic [CFG_W-1:0]         active_bits;
   xcfg_t [NOUT-1:0]         cfg_all;

   assign ib      = {in_w, in_s, in_e, in_n};
   assign cfg_all = active_bits;

   sbox_cfg_chain #(.NBITS(CFG_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_shift),
      .din      (cfg_din),
      .load     (cfg_load),
      .active_o (active_bits)
   );

   for (genvar d = 0; d < NSIDES; d++) begin : g_side
      localparam int SS = straight_side(d);
      localparam int LS = left_side(d);
      localparam int RS = right_side(d);

      sbox_side #(.W(W), .TOPO(TOPO)) u_side (
         .straight_bus (ib[SS]),
         .left_bus     (ib[LS]),
         .right_bus    (ib[RS]),
         .cfg_i        (cfg_all[d*W +: W]),
         .out_bus      (ob[d])
      );
   end

   assign out_n = ob[0];
   assign out_e = ob[1];
   assign out_s = ob[2];
   assign out_w = ob[3];

endmodule

// File: rtl/sbox_checker.sv
module sbox_checker
   import sbox_pkg::*;
#(
   parameter int    W    = 7,
   parameter topo_e TOPO = TOPO_WILTON
) (
   input logic         clk,
   input logic         rst,
   input logic         cfg_load,
   input logic [W-1:0] in_n,
   input logic [W-1:0] in_e,
   input logic [W-1:0] in_s,
   input logic [W-1:0] in_w,
   input logic [W-1:0] out_n,
   input logic [W-1:0] out_e,
   input logic [W-1:0] out_s,
   input logic [W-1:0] out_w
);

   logic [NSIDES-1:0][W-1:0] ib;
   logic [NSIDES-1:0][W-1:0] ob;

   assign ib = {in_w, in_s, in_e, in_n};
   assign ob = {out_w, out_s, out_e, out_n};

   AST_RESET_DARK: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ob == '0)) else $error("outputs active right after reset"); // R1

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cfg_load) && $stable(ib)) |-> $stable(ob))
      else $error("routing changed without a load"); // R3

   AST_FANOUT_FS3: assert property (@(posedge clk) disable iff (rst)
      $countones(ob) <= 3 * $countones(ib))
      else $error("an input reaches more than three outputs"); // R9

   for (genvar d = 0; d < NSIDES; d++) begin : g_d
      for (genvar t = 0; t < W; t++) begin : g_t
         localparam int SS = straight_side(d);
         localparam int LS = left_side(d);
         localparam int RS = right_side(d);
         localparam int LT = (TOPO == TOPO_WILTON) ? (t + W - 1) % W : t;
         localparam int RT = (TOPO == TOPO_WILTON) ? (W - 1 - t) : t;

         AST_CAND_SRC: assert property (@(posedge clk) disable iff (rst)
            ob[d][t] |-> (ib[SS][t] | ib[LS][LT] | ib[RS][RT]))
            else $error("output active with no candidate source active"); // R6
      end
   end

endmodule

bind sbox_switch_box sbox_checker #(.W(W), .TOPO(TOPO)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cfg_load (cfg_load),
   .in_n     (in_n),
   .in_e     (in_e),
   .in_s     (in_s),
   .in_w     (in_w),
   .out_n    (out_n),
   .out_e    (out_e),
   .out_s    (out_s),
   .out_w    (out_w)
);

// File: tb/sbox_switch_box_tb.sv
`timescale 1ns/1ps
module sbox_switch_box_tb_top;
   import sbox_pkg::*;

   localparam int W    = 7;
   localparam int NB   = 4 * W;
   localparam int CW   = NB * 3;
   localparam int NVEC = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_shift = 1'b0;
   logic cfg_din = 1'b0;
   logic cfg_load = 1'b0;
   logic [NB-1:0] pin = '0;
   logic [W-1:0] wn, we, ws, ww;
   logic [W-1:0] dn, de, ds, dw;
   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sbox_switch_box #(.W(W), .TOPO(TOPO_WILTON)) dut_i (
      .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din), .cfg_load(cfg_load),
      .in_n(pin[0*W +: W]), .in_e(pin[1*W +: W]), .in_s(pin[2*W +: W]), .in_w(pin[3*W +: W]),
      .out_n(wn), .out_e(we), .out_s(ws), .out_w(ww)
   );

   sbox_switch_box #(.W(W), .TOPO(TOPO_DISJOINT)) dut_dj_i (
      .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din), .cfg_load(cfg_load),
      .in_n(pin[0*W +: W]), .in_e(pin[1*W +: W]), .in_s(pin[2*W +: W]), .in_w(pin[3*W +: W]),
      .out_n(dn), .out_e(de), .out_s(ds), .out_w(dw)
   );

   // vector: [33:32] select for all tracks, [31:28] per-side enable, [27:0] inputs {w,s,e,n}
   localparam logic [33:0] VEC [NVEC] = '{
      {2'd0, 4'hF, 28'h0000001},
      {2'd0, 4'hF, 28'hA5C3E17},
      {2'd1, 4'hF, 28'h0000001},
      {2'd1, 4'hF, 28'h8000040},
      {2'd1, 4'hF, 28'h3F1B2C4},
      {2'd2, 4'hF, 28'h0000001},
      {2'd2, 4'hF, 28'h0204081},
      {2'd2, 4'hF, 28'hC0FFEE5},
      {2'd3, 4'hF, 28'hFFFFFFF},
      {2'd0, 4'h5, 28'hFFFFFFF},
      {2'd1, 4'hA, 28'h1234567},
      {2'd2, 4'h6, 28'h7654321}
   };

   function automatic logic [CW-1:0] mk_cfg(input logic [1:0] sel, input logic [3:0] side_en);
      logic [CW-1:0] c = '0;
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < W; t++) begin
            c[3*(s*W+t) +: 2] = sel;
            c[3*(s*W+t) + 2]  = side_en[s];
         end
      return c;
   endfunction

   function automatic logic [CW-1:0] mk_one(input int s, input int t, input logic [1:0] sel);
      logic [CW-1:0] c = '0;
      c[3*(s*W+t) +: 2] = sel;
      c[3*(s*W+t) + 2]  = 1'b1;
      return c;
   endfunction

   // expected outputs computed from R4..R8
   function automatic logic [NB-1:0] model(input logic [CW-1:0] c, input logic [NB-1:0] p,
                                           input bit wil);
      logic [NB-1:0] r = '0;
      for (int d = 0; d < 4; d++)
         for (int t = 0; t < W; t++) begin
            int k = d*W + t;
            logic [1:0] sel = c[3*k +: 2];
            if (c[3*k+2]) begin
               case (sel)
                  2'd0: r[k] = p[((d+2)%4)*W + t];
                  2'd1: r[k] = p[((d+3)%4)*W + (wil ? (t+W-1)%W : t)];
                  2'd2: r[k] = p[((d+1)%4)*W + (wil ? (W-1-t) : t)];
                  default: r[k] = 1'b0;
               endcase
            end
         end
      return r;
   endfunction

   task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_cfg(input logic [CW-1:0] c);
      for (int i = 0; i < CW; i++) begin
         @(negedge clk);
         cfg_shift = 1'b1;
         cfg_din   = c[i];
      end
      @(negedge clk);
      cfg_shift = 1'b0;
      cfg_din   = 1'b0;
   endtask

   task automatic pulse_load();
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [CW-1:0] c;
      logic [NB-1:0] all_w, all_d;
      pin = '1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 wilton reset", {ww, ws, we, wn}, '0);
      chk("R1 disjoint reset", {dw, ds, de, dn}, '0);
      @(negedge clk);
      pulse_load();
      chk("R1 load after reset", {ww, ws, we, wn}, '0);

      // R3: shifted but not loaded has no effect
      c = mk_cfg(2'd0, 4'hF);
      shift_cfg(c);
      #1;
      chk("R3 staged only", {ww, ws, we, wn}, '0);
      pulse_load();
      chk("R3 after load", {ww, ws, we, wn}, '1);
      shift_cfg('0);
      #1;
      chk("R3 old config kept while reshifting", {ww, ws, we, wn}, '1);
      pulse_load();
      chk("R3 reload to all off", {ww, ws, we, wn}, '0);

      // R2: field position for south track 4, straight
      shift_cfg(mk_one(2, 4, 2'd0));
      pulse_load();
      chk("R2 single field position", {ww, ws, we, wn}, 28'h1 << (2*W + 4));

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         logic [1:0] sel = VEC[v][33:32];
         logic [3:0] en  = VEC[v][31:28];
         tag = (sel == 2'd0) ? "R5" : (sel == 2'd1) ? "R6" : (sel == 2'd2) ? "R7" : "R8";
         if (en != 4'hF) tag = {tag, "/R4"};
         c = mk_cfg(sel, en);
         shift_cfg(c);
         pulse_load();
         pin = VEC[v][27:0];
         #1;
         chk({tag, " wilton"}, {ww, ws, we, wn}, model(c, pin, 1'b1));
         chk({tag, " disjoint"}, {dw, ds, de, dn}, model(c, pin, 1'b0));
      end

      // R9: one hot input, all outputs enabled, each select gives exactly one output
      for (int sel = 0; sel < 3; sel++) begin
         shift_cfg(mk_cfg(sel[1:0], 4'hF));
         pulse_load();
         for (int b = 0; b < NB; b += 5) begin
            pin = '0;
            pin[b] = 1'b1;
            #1;
            all_w = {ww, ws, we, wn};
            all_d = {dw, ds, de, dn};
            chk("R9 wilton single fanout", NB'($countones(all_w)), NB'(1));
            chk("R9 disjoint single fanout", NB'($countones(all_d)), NB'(1));
         end
      end

      // R10: west track 0 to north track 1
      pin = '0;
      pin[3*W + 0] = 1'b1;
      shift_cfg(mk_one(0, 1, 2'd1));
      pulse_load();
      chk("R10 wilton routes west0 to north1", {ww, ws, we, wn}, 28'h1 << 1);
      for (int sel = 0; sel < 4; sel++) begin
         shift_cfg(mk_one(0, 1, sel[1:0]));
         pulse_load();
         chk("R10 disjoint cannot reach north1", {dw, ds, de, dn}, '0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule